// File: doc/BRIEF.md
# Abort and Transfer Permission Gate

This block sits between a register bus slave and a memory-mapped master. For each register bus access it decides whether the access may start a master transaction, must be refused with a locally generated error, or is a plain register access that completes at once. It also keeps a transfer-in-progress status bit that shows whether a master transaction is still outstanding.

A debug abort ends a waiting register bus access on the next cycle. The status bit stays set until the master completion actually arrives. While that bit is high, writes and accesses that would start a master transaction are refused locally. Every error carries a source flag. The flag says whether the port refused the access or the master returned the error. The debug enable and secure debug enable inputs are checked against a protection bit. A refused transfer never reaches the master.

Top module: `abort_perm_gate`

## Requirements
- R1: An access with acc_launch=1 starts a master transaction only if dbg_en=1 and either acc_prot[NS_BIT]=1 (non-secure) or sec_dbg_en=1. Otherwise mst_launch stays low, and on the next cycle acc_done=1, acc_err=1 and err_from_ap=1.
- R2: When xfer_busy=0 and the access is permitted, mst_launch is high in the same cycle as acc_start. xfer_busy is high from the next cycle.
- R3: xfer_busy clears on the cycle after mst_done. If a register bus access is still waiting, that same cycle shows acc_done=1, acc_err=mst_err and err_from_ap=0.
- R4: abort_req while an access waits for the master (without mst_done) gives acc_done=1, acc_err=1 and err_from_ap=1 on the next cycle. xfer_busy stays high until mst_done.
- R5: While xfer_busy=1, any access with acc_write=1 is refused: no mst_launch, and on the next cycle acc_done=1, acc_err=1 and err_from_ap=1.
- R6: While xfer_busy=1, a read with acc_launch=1 is refused in the same way as R5.
- R7: While xfer_busy=1, a read with acc_launch=0 completes on the next cycle with acc_err=0, and xfer_busy stays readable as 1.
- R8: Any error shown while xfer_busy=1 has err_from_ap=1.
- R9: abort_req when no access is waiting has no effect: no acc_done, and xfer_busy is unchanged. This covers a second abort.
- R10: Reset (rst_n=0 at a clock edge) clears xfer_busy, acc_done, acc_err and err_from_ap.
- R11: While idle, an access with acc_launch=0 completes on the next cycle without error, whatever the permission inputs are.
- R12: When mst_done and abort_req arrive in the same cycle for a waiting access, the master completion wins and is reported as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | One-cycle strobe: a register bus access begins |
| acc_write | input | 1 | Access is a write |
| acc_launch | input | 1 | Access targets the data window or banked registers and would start a master transaction |
| acc_prot | input | PROT_W | Requested protection; bit NS_BIT=1 means non-secure |
| dbg_en | input | 1 | Debug enable |
| sec_dbg_en | input | 1 | Secure debug enable |
| abort_req | input | 1 | Debug abort request |
| mst_done | input | 1 | Master transaction completed |
| mst_err | input | 1 | Master completion carried an error |
| mst_launch | output | 1 | Start a master transaction (same cycle as acc_start) |
| xfer_busy | output | 1 | Transfer-in-progress status bit |
| acc_done | output | 1 | Register bus access completes this cycle |
| acc_err | output | 1 | Completion is an error |
| err_from_ap | output | 1 | Error was generated by the port (0: system error) |

## Verification
The bench builds the gate with its default PROT_W=3 and NS_BIT=1, so the protection bit it drives is acc_prot[1]. This is enough to cover every row of the permission decision and the full abort window. Inside that window it issues writes, launching reads, plain reads and repeated aborts. It also checks that a master completion arriving in the same cycle as an abort takes precedence.

// File: rtl/abort_perm_gate_pkg.sv
// Package: shared response kind for the abort and permission gate.
// Assumes: one response at most per cycle.
package abort_perm_gate_pkg;
    typedef enum logic [1:0] {
        RSP_NONE = 2'd0,
        RSP_OK   = 2'd1,
        RSP_SYS  = 2'd2,
        RSP_PORT = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/gate_perm_check.sv
// Module: gate_perm_check
// Decides from the debug enables and the protection field whether a
// master transaction may be started. Purely combinational.
// Assumes: bit NS_BIT of the protection field is 1 for non-secure.
module gate_perm_check #(
    parameter int PROT_W = 3,
    parameter int NS_BIT = 1
) (
    input  logic [PROT_W-1:0] prot_i,
    input  logic              dbg_en_i,
    input  logic              sec_dbg_en_i,
    output logic              permitted_o
);
    logic non_secure;

    // Extract the security attribute of the request
    assign non_secure  = prot_i[NS_BIT];
    // Secure requests additionally need the secure debug enable
    assign permitted_o = dbg_en_i & (non_secure | sec_dbg_en_i);
endmodule

// File: rtl/gate_xfer_tracker.sv
// Module: gate_xfer_tracker
// Holds the transfer-in-progress bit and the "access waiting on master"
// flag, and classifies each event into a response kind.
// Assumes: the register bus issues no new access while one is waiting,
// and mst_done only arrives while a transfer is outstanding.
module gate_xfer_tracker
    import abort_perm_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      acc_start_i,
    input  logic      acc_write_i,
    input  logic      acc_launch_i,
    input  logic      permitted_i,
    input  logic      abort_i,
    input  logic      done_i,
    input  logic      err_i,
    output logic      launch_o,
    output logic      busy_o,
    output rsp_kind_e rsp_o
);
    logic busy_q;
    logic wait_q;
    logic busy_hit;

    // An access the port must refuse because a transfer is still draining
    assign busy_hit = busy_q & (acc_write_i | acc_launch_i);

    // Classify the current cycle into a launch and/or a response
    always_comb begin
        launch_o = 1'b0;
        rsp_o    = RSP_NONE;
        if (acc_start_i) begin
            if (busy_hit) begin
                rsp_o = RSP_PORT;
            end else if (acc_launch_i && !permitted_i) begin
                rsp_o = RSP_PORT;
            end else if (acc_launch_i) begin
                launch_o = 1'b1;
            end else begin
                rsp_o = RSP_OK;
            end
        end else if (wait_q) begin
            if (done_i) begin
                rsp_o = err_i ? RSP_SYS : RSP_OK;
            end else if (abort_i) begin
                rsp_o = RSP_PORT;
            end
        end
    end

    // Track outstanding master transfer and waiting register access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wait_q <= 1'b0;
        end else if (launch_o) begin
            busy_q <= 1'b1;
            wait_q <= 1'b1;
        end else begin
            if (done_i) begin
                busy_q <= 1'b0;
            end
            if (wait_q && !acc_start_i && (done_i || abort_i)) begin
                wait_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/gate_resp_reg.sv
// Module: gate_resp_reg
// Registers the response kind onto the register bus completion outputs.
// Assumes: err_from_ap is only meaningful together with an error.
module gate_resp_reg
    import abort_perm_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rsp_kind_e rsp_i,
    output logic      done_o,
    output logic      err_o,
    output logic      ap_o
);
    // Present the classified response one cycle after its event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            ap_o   <= 1'b0;
        end else begin
            done_o <= (rsp_i != RSP_NONE);
            err_o  <= (rsp_i == RSP_SYS) || (rsp_i == RSP_PORT);
            ap_o   <= (rsp_i == RSP_PORT);
        end
    end
endmodule

// File: rtl/abort_perm_gate.sv
// Module: abort_perm_gate (top)
// Gates register bus accesses onto a memory-mapped master. It refuses
// accesses locally when debug permission is missing or when a transfer
// is still draining after an abort, and labels the source of each error.
// Assumes: synchronous active-low reset, one register access at a time.
module abort_perm_gate
    import abort_perm_gate_pkg::*;
#(
    parameter int PROT_W = 3,
    parameter int NS_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              acc_write,
    input  logic              acc_launch,
    input  logic [PROT_W-1:0] acc_prot,
    input  logic              dbg_en,
    input  logic              sec_dbg_en,
    input  logic              abort_req,
    input  logic              mst_done,
    input  logic              mst_err,
    output logic              mst_launch,
    output logic              xfer_busy,
    output logic              acc_done,
    output logic              acc_err,
    output logic              err_from_ap
);
    logic      permitted;
    rsp_kind_e rsp_kind;

    // Permission decision from the debug enables
    gate_perm_check #(.PROT_W(PROT_W), .NS_BIT(NS_BIT)) u_perm (
        .prot_i       (acc_prot),
        .dbg_en_i     (dbg_en),
        .sec_dbg_en_i (sec_dbg_en),
        .permitted_o  (permitted)
    );

    // Outstanding-transfer tracking and event classification
    gate_xfer_tracker u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_start_i  (acc_start),
        .acc_write_i  (acc_write),
        .acc_launch_i (acc_launch),
        .permitted_i  (permitted),
        .abort_i      (abort_req),
        .done_i       (mst_done),
        .err_i        (mst_err),
        .launch_o     (mst_launch),
        .busy_o       (xfer_busy),
        .rsp_o        (rsp_kind)
    );

    // Registered completion onto the register bus
    gate_resp_reg u_resp (
        .clk    (clk),
        .rst_n  (rst_n),
        .rsp_i  (rsp_kind),
        .done_o (acc_done),
        .err_o  (acc_err),
        .ap_o   (err_from_ap)
    );
endmodule

// File: rtl/abort_perm_gate_chk.sv
// Module: abort_perm_gate_chk
// Property checker for abort_perm_gate, attached with bind below.
// Assumes: same reset and clock as the gate.
module abort_perm_gate_chk #(
    parameter int PROT_W = 3,
    parameter int NS_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_start,
    input logic              acc_write,
    input logic [PROT_W-1:0] acc_prot,
    input logic              dbg_en,
    input logic              sec_dbg_en,
    input logic              abort_req,
    input logic              mst_done,
    input logic              mst_launch,
    input logic              xfer_busy,
    input logic              acc_done,
    input logic              acc_err,
    input logic              err_from_ap
);
    logic pend_q;

    // Observer: a launched access waits until its completion appears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (mst_launch) begin
            pend_q <= 1'b1;
        end else if (acc_done) begin
            pend_q <= 1'b0;
        end
    end

    assert_launch_perm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mst_launch |-> (dbg_en && (acc_prot[NS_BIT] || sec_dbg_en)));

    assert_launch_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mst_launch |=> xfer_busy);

    assert_done_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && mst_done) |=> !xfer_busy);

    assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !mst_done) |=> xfer_busy);

    assert_abort_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !acc_done && abort_req && !mst_done) |=> (acc_done && acc_err && err_from_ap));

    assert_busy_write_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && xfer_busy && acc_write) |=> (acc_done && acc_err && err_from_ap));

    assert_no_launch_when_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mst_launch |-> !xfer_busy);

    assert_busy_err_from_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && xfer_busy) |-> err_from_ap);

    assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_done);
endmodule

bind abort_perm_gate abort_perm_gate_chk #(.PROT_W(PROT_W), .NS_BIT(NS_BIT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_start   (acc_start),
    .acc_write   (acc_write),
    .acc_prot    (acc_prot),
    .dbg_en      (dbg_en),
    .sec_dbg_en  (sec_dbg_en),
    .abort_req   (abort_req),
    .mst_done    (mst_done),
    .mst_launch  (mst_launch),
    .xfer_busy   (xfer_busy),
    .acc_done    (acc_done),
    .acc_err     (acc_err),
    .err_from_ap (err_from_ap)
);

// File: tb/abort_perm_gate_tb_top.sv
// Bench for abort_perm_gate: a behavioural reference model is stepped
// each cycle and every output is compared against it.
module abort_perm_gate_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_start = 1'b0, acc_write = 1'b0, acc_launch = 1'b0;
    logic [2:0] acc_prot = 3'b000;
    logic       dbg_en = 1'b0, sec_dbg_en = 1'b0;
    logic       abort_req = 1'b0, mst_done = 1'b0, mst_err = 1'b0;
    logic       mst_launch, xfer_busy, acc_done, acc_err, err_from_ap;

    int    compared = 0;
    int    mismatched = 0;
    string tag = "R10";
    bit    finished = 1'b0;

    // Reference model state
    bit m_busy = 0, m_wait = 0, e_done = 0, e_err = 0, e_ap = 0;

    always #10 clk = ~clk;

    abort_perm_gate dut_i (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_write(acc_write),
        .acc_launch(acc_launch), .acc_prot(acc_prot), .dbg_en(dbg_en),
        .sec_dbg_en(sec_dbg_en), .abort_req(abort_req), .mst_done(mst_done),
        .mst_err(mst_err), .mst_launch(mst_launch), .xfer_busy(xfer_busy),
        .acc_done(acc_done), .acc_err(acc_err), .err_from_ap(err_from_ap)
    );

    task automatic chk(input string nm, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic chk_regs();
        chk("xfer_busy", xfer_busy, m_busy);
        chk("acc_done", acc_done, e_done);
        chk("acc_err", acc_err, e_err);
        chk("err_from_ap", err_from_ap, e_ap);
    endtask

    // One cycle: drive at negedge, check launch, advance model, check after edge
    task automatic step(input bit st, input bit wr, input bit ln, input bit ns,
                        input bit ab, input bit dn, input bit er);
        bit hit, perm, exp_launch;
        acc_start = st; acc_write = wr; acc_launch = ln;
        acc_prot = {1'b0, ns, 1'b0};
        abort_req = ab; mst_done = dn; mst_err = er;
        #1;
        hit  = m_busy && (wr || ln);
        perm = dbg_en && (ns || sec_dbg_en);
        exp_launch = st && ln && !hit && perm;
        chk("mst_launch", mst_launch, exp_launch);
        e_done = 0; e_err = 0; e_ap = 0;
        if (st) begin
            if (hit || (ln && !perm)) begin
                e_done = 1; e_err = 1; e_ap = 1;
            end else if (!ln) begin
                e_done = 1;
            end
        end else if (m_wait) begin
            if (dn) begin
                e_done = 1; e_err = er; m_wait = 0;
            end else if (ab) begin
                e_done = 1; e_err = 1; e_ap = 1; m_wait = 0;
            end
        end
        if (exp_launch) begin
            m_busy = 1; m_wait = 1;
        end else if (dn) begin
            m_busy = 0;
        end
        @(negedge clk);
        chk_regs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        tag = "R10";
        chk_regs();
        rst_n = 1'b1;
        idle(2);

        // R11: plain access while idle, no permission at all
        tag = "R11"; dbg_en = 0; sec_dbg_en = 0;
        step(1, 0, 0, 0, 0, 0, 0); idle(1);
        step(1, 1, 0, 1, 0, 0, 0); idle(1);

        // R1: blocked with debug disabled, then secure without secure debug
        tag = "R1";
        step(1, 0, 1, 1, 0, 0, 0); idle(1);
        dbg_en = 1;
        step(1, 1, 1, 0, 0, 0, 0); idle(1);

        // R2/R3: non-secure launch, system error completion
        tag = "R2"; step(1, 0, 1, 1, 0, 0, 0); idle(3);
        tag = "R3"; step(0, 0, 0, 0, 0, 1, 1); idle(1);

        // R1/R3: secure launch with secure debug, clean completion
        tag = "R1"; sec_dbg_en = 1;
        step(1, 1, 1, 0, 0, 0, 0); idle(2);
        tag = "R3"; step(0, 0, 0, 0, 0, 1, 0); idle(1);

        // R4: abort during transfer
        tag = "R4"; step(1, 0, 1, 1, 0, 0, 0); idle(1);
        step(0, 0, 0, 0, 1, 0, 0); idle(2);
        tag = "R9"; step(0, 0, 0, 0, 1, 0, 0); idle(1);
        tag = "R5"; step(1, 1, 0, 1, 0, 0, 0); idle(1);
        step(1, 1, 1, 1, 0, 0, 0); idle(1);
        tag = "R6"; step(1, 0, 1, 1, 0, 0, 0); idle(1);
        tag = "R8"; step(1, 0, 1, 0, 0, 0, 0); idle(1);
        tag = "R7"; step(1, 0, 0, 1, 0, 0, 0); idle(1);
        tag = "R3"; step(0, 0, 0, 0, 0, 1, 1); idle(2);

        // R12: abort and completion in the same cycle
        tag = "R12"; step(1, 0, 1, 1, 0, 0, 0); idle(1);
        step(0, 0, 0, 0, 1, 1, 1); idle(1);
        step(1, 1, 1, 1, 0, 0, 0); idle(1);
        step(0, 0, 0, 0, 1, 1, 0); idle(1);

        // R9: abort while idle does nothing
        tag = "R9"; step(0, 0, 0, 0, 1, 0, 0); idle(2);

        // R1: permission removed again after use
        tag = "R1"; sec_dbg_en = 0;
        step(1, 0, 1, 0, 0, 0, 0); idle(1);
        step(1, 0, 1, 1, 0, 0, 0); idle(1);
        step(0, 0, 0, 0, 0, 1, 0); idle(2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule